// File: doc/BRIEF.md
# Sequential Bit Delay Line on a One-Bit DRAM

This controller turns a single one-bit-wide DRAM into a circular store of bits that is walked strictly in order. Each sample strobe stores one bit, fetches one bit, or fetches one bit and then overwrites it in the same place. The result is a plain recorder, a playback source, or a fixed delay line whose length in samples is set by a configuration input. A typical use is delaying a one-bit delta-modulated audio stream by up to about a second.

Only the column part of the address goes to the memory's address pins, through a 9-bit counter. The row part is never driven. The memory uses its own refresh row counter, which advances by one on every cycle in which CAS falls before RAS. The controller steps to the next row by issuing one such cycle each time the column counter wraps. At the end of the programmed ring it issues enough of them to bring the row counter back to zero. Refresh therefore comes as a side effect of the sweep. The controller keeps a shadow copy of the row so that it can compare positions against the ring limit, and it assumes that the memory's counter is zero when reset is released.

Positions are numbered as row × 512 + column. The ring covers positions 0 through `ring_last`, so it holds `ring_last` + 1 bits. With an 8-bit row counter the largest ring is 131072 bits.

Top module: `bitring_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are in this state: `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `busy` is low, `bit_out` is 0 and `dram_addr` is 0.
- R2: With `mode` = 2'b00 (record), an accepted strobe performs one write of `bit_in` at the current position and no read, and `bit_out` keeps its previous value.
- R3: With `mode` = 2'b01 or 2'b11 (play), an accepted strobe performs one read at the current position, `bit_out` takes the stored bit, and `dram_we_n` stays high.
- R4: With `mode` = 2'b10 (delay), an accepted strobe reads the current position into `bit_out` and then writes `bit_in` to the same position, within one RAS-low period. The bit appears on `bit_out` exactly `ring_last` + 1 accepted strobes after it was given.
- R5: In a data access, RAS stays low with CAS high for `T_RCD` clocks before CAS falls. Each CAS-low phase lasts `T_CAS` clocks and the precharge lasts `T_RP` clocks. WE is low only while both RAS and CAS are low, and in delay mode only after the read phase.
- R6: The column presented on `dram_addr` at the falling edge of RAS equals the ring position modulo 512, and it advances by one per completed access.
- R7: When the column wraps from 511 to 0 inside the ring, exactly one refresh-counter step (CAS low before RAS falls) is issued before `busy` drops.
- R8: When the access at position `ring_last` completes, the column is cleared and (512 − row) mod 256 refresh-counter steps are issued, so the memory's row counter returns to zero and the next access is at position 0.
- R9: `busy` is high from the clock after a strobe is accepted until the access and all its refresh-counter steps are done. A strobe while `busy` is high is ignored: no extra access, no change of the latched mode or data, no pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one clock wide, accepted only when `busy` is low |
| bit_in | input | 1 | Bit to be stored on this strobe |
| mode | input | 2 | 00 record, 01 play, 10 delay, 11 play |
| ring_last | input | 17 | Last ring position (row × 512 + column); hold it static |
| busy | output | 1 | Access sequence in progress |
| bit_out | output | 1 | Most recently read bit |
| dram_ras_n | output | 1 | Row strobe to memory, active low |
| dram_cas_n | output | 1 | Column strobe to memory, active low |
| dram_we_n | output | 1 | Write enable to memory, active low |
| dram_addr | output | 9 | Column address to memory |
| dram_d | output | 1 | Write data to memory |
| dram_q | input | 1 | Read data from memory |

## Verification
A column counter that has drifted shows at the very next falling edge of RAS, because `dram_addr` no longer matches position modulo 512. A shadow row that has lost step with the memory shows only at the end of the ring, as the wrong number of refresh-counter steps and a memory counter that does not land on zero. Corrupted latched mode or data shows within the same access, as a missing or extra WE pulse. Corrupted stored data in delay mode surfaces one full ring length later on `bit_out`, so the bench runs delay passes longer than one ring and compares every output against a reference ring.

// File: rtl/bitring_pkg.sv
// Shared types for the sequential bit ring controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package bitring_pkg;

    // Operating mode carried on the mode input
    typedef enum logic [1:0] {
        MD_RECORD   = 2'b00,
        MD_PLAY     = 2'b01,
        MD_DELAY    = 2'b10,
        MD_PLAY_ALT = 2'b11
    } ring_mode_e;

    // Phases of the memory access sequencer
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RCD,
        PH_READ,
        PH_WRITE,
        PH_PRE,
        PH_ADV,
        PH_CBR_CAS,
        PH_CBR_RAS,
        PH_CBR_PRE
    } ring_phase_e;

    // Row strobe is active in these phases
    function automatic logic phase_ras_low(ring_phase_e p);
        return (p == PH_RCD) || (p == PH_READ) || (p == PH_WRITE) || (p == PH_CBR_RAS);
    endfunction

    // Column strobe is active in these phases
    function automatic logic phase_cas_low(ring_phase_e p);
        return (p == PH_READ) || (p == PH_WRITE) || (p == PH_CBR_CAS) || (p == PH_CBR_RAS);
    endfunction

    // Write enable is active only in the write phase
    function automatic logic phase_we_low(ring_phase_e p);
        return (p == PH_WRITE);
    endfunction

endpackage

// File: rtl/bitring_hold.sv
// Phase duration counter.
// Does: counts down from a loaded value; 'expired' is high once it reaches zero,
//       so a phase entered with load value N-1 lasts N clocks.
// Assumes: load is pulsed on the transition into the timed phase.
module bitring_hold #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bitring_pos.sv
// Ring position tracker.
// Does: holds the column counter driven to the memory and a shadow of the
//       memory's internal refresh row counter; decides after each access
//       how many refresh-counter steps must follow (one on column wrap,
//       enough to reach row zero at the ring limit).
// Assumes: the memory's row counter is zero when reset is released; step and
//          cbr_done are never high in the same cycle.
module bitring_pos #(
    parameter int COL_W       = 9,
    parameter int ROW_W       = 8,
    parameter int REFRESH_MAX = 4_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic                   cbr_done,
    input  logic [ROW_W+COL_W-1:0] ring_last,
    output logic [COL_W-1:0]       col,
    output logic                   cbr_req
);

    localparam int POS_W = ROW_W + COL_W;
    localparam int RW    = $clog2(REFRESH_MAX + 2);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] cbr_left_q;
    logic             at_limit;
    logic             col_top;
    logic [POS_W-1:0] pos_now;

    assign pos_now  = {row_q, col_q};
    assign at_limit = (pos_now == ring_last);
    assign col_top  = &col_q;

    // Advance the column after each access and track pending row steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q      <= '0;
            row_q      <= '0;
            cbr_left_q <= '0;
        end else if (step) begin
            if (at_limit) begin
                col_q      <= '0;
                cbr_left_q <= ROW_W'(0) - row_q;
            end else if (col_top) begin
                col_q      <= '0;
                cbr_left_q <= ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end else if (cbr_done) begin
            row_q      <= row_q + ROW_W'(1);
            cbr_left_q <= cbr_left_q - ROW_W'(1);
        end
    end

    assign col     = col_q;
    assign cbr_req = (cbr_left_q != '0);

    // Checker state: clocks since the ring last started at position zero
    logic [RW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (step && (pos_now == '0)) begin
            since_q <= '0;
        end else if (since_q <= RW'(REFRESH_MAX)) begin
            since_q <= since_q + RW'(1);
        end
    end

    // R6: an ordinary access moves the column on by exactly one
    a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_limit && !col_top) |=> (col_q == $past(col_q) + COL_W'(1)));

    // R7: a column wrap inside the ring queues exactly one row step
    a_r7_wrap_one_cbr: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col_top && !at_limit) |=> (col_q == '0 && cbr_left_q == ROW_W'(1)));

    // R8: at the ring limit the column clears and the row is driven home
    a_r8_limit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_limit) |=> (col_q == '0 && cbr_left_q == ROW_W'(0) - $past(row_q)));

    // R8: every pass (which sweeps all rows) restarts within the refresh bound
    a_r8_refresh_interval: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= RW'(REFRESH_MAX));

endmodule

// File: rtl/bitring_seq.sv
// Memory access sequencer.
// Does: accepts a strobe when idle, runs RAS -> CAS read and/or write ->
//       precharge, then as many CAS-before-RAS cycles as the position
//       tracker requests; drives registered strobes decoded from next phase.
// Assumes: T_RCD, T_CAS, T_RP are at least 1; memory read data is valid
//          before the last clock of the read phase.
module bitring_seq
    import bitring_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_CAS = 2,
    parameter int T_RP  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       bit_in,
    input  logic [1:0] mode,
    input  logic       cbr_req,
    input  logic       dram_q,
    output logic       step,
    output logic       cbr_done,
    output logic       busy,
    output logic       bit_out,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       wr_bit
);

    localparam int T_MAX0 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX  = (T_MAX0 > T_RP) ? T_MAX0 : T_RP;
    localparam int HOLD_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    ring_phase_e      state_q, state_d;
    ring_mode_e       mode_lat;
    logic             bit_lat;
    logic             bit_out_q;
    logic             ras_n_q, cas_n_q, we_n_q;
    logic             hold_load;
    logic [HOLD_W-1:0] hold_val;
    logic             hold_done;
    logic             accept;
    logic             capture;

    bitring_hold #(.CNT_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_val),
        .expired  (hold_done)
    );

    // Next-phase selection and phase timer loading
    always_comb begin
        state_d   = state_q;
        hold_load = 1'b0;
        hold_val  = '0;
        step      = 1'b0;
        cbr_done  = 1'b0;
        capture   = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (smp_stb) begin
                    accept    = 1'b1;
                    state_d   = PH_RCD;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_RCD - 1);
                end
            end
            PH_RCD: begin
                if (hold_done) begin
                    state_d   = (mode_lat == MD_RECORD) ? PH_WRITE : PH_READ;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_CAS - 1);
                end
            end
            PH_READ: begin
                if (hold_done) begin
                    capture   = 1'b1;
                    hold_load = 1'b1;
                    if (mode_lat == MD_DELAY) begin
                        state_d  = PH_WRITE;
                        hold_val = HOLD_W'(T_CAS - 1);
                    end else begin
                        state_d  = PH_PRE;
                        hold_val = HOLD_W'(T_RP - 1);
                    end
                end
            end
            PH_WRITE: begin
                if (hold_done) begin
                    state_d   = PH_PRE;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_RP - 1);
                end
            end
            PH_PRE: begin
                if (hold_done) begin
                    step    = 1'b1;
                    state_d = PH_ADV;
                end
            end
            PH_ADV: begin
                if (cbr_req) begin
                    state_d   = PH_CBR_CAS;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_RCD - 1);
                end else begin
                    state_d = PH_IDLE;
                end
            end
            PH_CBR_CAS: begin
                if (hold_done) begin
                    state_d   = PH_CBR_RAS;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_CAS - 1);
                end
            end
            PH_CBR_RAS: begin
                if (hold_done) begin
                    cbr_done  = 1'b1;
                    state_d   = PH_CBR_PRE;
                    hold_load = 1'b1;
                    hold_val  = HOLD_W'(T_RP - 1);
                end
            end
            PH_CBR_PRE: begin
                if (hold_done) begin
                    state_d = PH_ADV;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Latch mode and data for the duration of one access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lat <= MD_RECORD;
            bit_lat  <= 1'b0;
        end else if (accept) begin
            mode_lat <= ring_mode_e'(mode);
            bit_lat  <= bit_in;
        end
    end

    // Capture the memory's read data at the end of the read phase
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_out_q <= 1'b0;
        else if (capture) bit_out_q <= dram_q;
    end

    // Registered strobes decoded from the phase being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            we_n_q  <= 1'b1;
        end else begin
            ras_n_q <= !phase_ras_low(state_d);
            cas_n_q <= !phase_cas_low(state_d);
            we_n_q  <= !phase_we_low(state_d);
        end
    end

    assign busy    = (state_q != PH_IDLE);
    assign bit_out = bit_out_q;
    assign ras_n   = ras_n_q;
    assign cas_n   = cas_n_q;
    assign we_n    = we_n_q;
    assign wr_bit  = bit_lat;

    // R9: a strobe during an access leaves the latched request untouched
    a_r9_busy_ignores_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && smp_stb) |=> ($stable(mode_lat) && $stable(bit_lat)));

    // R5: in a data access CAS falls only after RAS has already been low
    a_r5_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_q) && !ras_n_q) |-> $past(!ras_n_q));

    // R5: write enable only inside an open row and column
    a_r5_we_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_q |-> (!ras_n_q && !cas_n_q));

    // R5: in delay mode the write phase follows the read phase directly
    a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n_q) && mode_lat == MD_DELAY) |-> $past(!cas_n_q && we_n_q));

endmodule

// File: rtl/bitring_ctrl.sv
// Sequential bit ring controller on a one-bit-wide DRAM (top level).
// Does: one record, play or delay access per sample strobe, column from its
//       own counter, row from the memory's refresh counter stepped by
//       CAS-before-RAS cycles.
// Assumes: memory row counter is zero at reset release; ring_last is static;
//          strobes are spaced beyond the worst busy time.
module bitring_ctrl #(
    parameter int COL_W       = 9,
    parameter int ROW_W       = 8,
    parameter int T_RCD       = 2,
    parameter int T_CAS       = 2,
    parameter int T_RP        = 2,
    parameter int REFRESH_MAX = 4_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_stb,
    input  logic                   bit_in,
    input  logic [1:0]             mode,
    input  logic [ROW_W+COL_W-1:0] ring_last,
    output logic                   busy,
    output logic                   bit_out,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic [COL_W-1:0]       dram_addr,
    output logic                   dram_d,
    input  logic                   dram_q
);

    logic step;
    logic cbr_done;
    logic cbr_req;

    bitring_pos #(
        .COL_W       (COL_W),
        .ROW_W       (ROW_W),
        .REFRESH_MAX (REFRESH_MAX)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .cbr_done  (cbr_done),
        .ring_last (ring_last),
        .col       (dram_addr),
        .cbr_req   (cbr_req)
    );

    bitring_seq #(
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RP  (T_RP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .bit_in   (bit_in),
        .mode     (mode),
        .cbr_req  (cbr_req),
        .dram_q   (dram_q),
        .step     (step),
        .cbr_done (cbr_done),
        .busy     (busy),
        .bit_out  (bit_out),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .wr_bit   (dram_d)
    );

endmodule

// File: tb/bitring_ctrl_bench.sv
`timescale 1ns/1ps
module bitring_ctrl_bench;

    localparam int L     = 600;
    localparam int COLS  = 512;
    localparam int T_RCD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [16:0] ring_last = 17'(L - 1);
    logic        busy, bit_out, dram_ras_n, dram_cas_n, dram_we_n, dram_d;
    logic [8:0]  dram_addr;
    logic        dram_q;

    always #2 clk = ~clk;

    bitring_ctrl u_bitring_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_in(bit_in), .mode(mode),
        .ring_last(ring_last), .busy(busy), .bit_out(bit_out),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_d(dram_d), .dram_q(dram_q)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic end_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Behavioural memory: row from its own refresh counter, steps on CAS-before-RAS
    bit   dmem[int];
    int   refcnt = 0;
    int   open_row = 0;
    bit   in_acc = 1'b0;
    logic m_prev_ras = 1'b1;
    logic dq = 1'b0;
    assign dram_q = dq;

    always @(negedge clk) begin
        if (!rst_n) begin
            refcnt = 0; in_acc = 1'b0; m_prev_ras = 1'b1; dq <= 1'b0;
        end else begin
            if (m_prev_ras && !dram_ras_n) begin
                if (!dram_cas_n) refcnt = (refcnt + 1) % 256;
                else begin open_row = refcnt; in_acc = 1'b1; end
            end
            if (dram_ras_n) in_acc = 1'b0;
            if (in_acc && !dram_ras_n && !dram_cas_n) begin
                if (!dram_we_n) dmem[open_row * COLS + int'(dram_addr)] = dram_d;
                else if (dmem.exists(open_row * COLS + int'(dram_addr)))
                    dq <= dmem[open_row * COLS + int'(dram_addr)];
                else dq <= 1'b0;
            end
            m_prev_ras = dram_ras_n;
        end
    end

    // Scoreboard queues filled by the driver
    bit    sb_exp[$];
    string sb_req[$];

    // Pin monitor and scoreboard consumer
    int n_acc = 0, n_cbr = 0, n_we = 0, we_bad = 0, rcd_bad = 0, acc_pos = 0, ras_run = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                if (dram_cas_n) begin
                    n_acc++;
                    chk(int'(dram_addr) == acc_pos % COLS, "R6 column at RAS fall",
                        int'(dram_addr), acc_pos % COLS);
                    acc_pos = (acc_pos + 1) % L;
                end else n_cbr++;
            end
            if (!dram_ras_n && dram_cas_n) ras_run++;
            if (dram_ras_n) ras_run = 0;
            if (p_cas && !dram_cas_n && !dram_ras_n && ras_run < T_RCD) rcd_bad++;
            if (p_we && !dram_we_n) n_we++;
            if (!dram_we_n && (dram_ras_n || dram_cas_n)) we_bad++;
            if (p_busy && !busy) begin
                if (sb_exp.size() == 0) chk(1'b0, "R9 completion without request", 1, 0);
                else begin
                    bit e; string r;
                    e = sb_exp.pop_front(); r = sb_req.pop_front();
                    chk(bit_out == e, r, int'(bit_out), int'(e));
                end
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_busy = busy;
        end
    end

    // Reference ring for expected values
    bit ref_mem[int];
    int drv_pos = 0;
    bit last_out = 1'b0;

    function automatic bit ref_rd(int p);
        if (ref_mem.exists(p)) return ref_mem[p];
        return 1'b0;
    endfunction

    function automatic bit pat(int s, int i);
        return bit'((((i * 37) + s) ^ (i >> 2)) & 1);
    endfunction

    // Push the expectation for one strobe according to the mode rules
    task automatic expect_item(input logic [1:0] md, input bit b);
        bit e;
        case (md)
            2'b00: begin e = last_out; ref_mem[drv_pos] = b; sb_req.push_back("R2 record keeps bit_out"); end
            2'b10: begin e = ref_rd(drv_pos); ref_mem[drv_pos] = b; last_out = e; sb_req.push_back("R4 delayed bit"); end
            default: begin e = ref_rd(drv_pos); last_out = e; sb_req.push_back("R3 played bit"); end
        endcase
        sb_exp.push_back(e);
        drv_pos = (drv_pos + 1) % L;
    endtask

    task automatic sample(input logic [1:0] md, input bit b);
        @(negedge clk);
        while (busy) @(negedge clk);
        smp_stb = 1'b1; mode = md; bit_in = b;
        expect_item(md, b);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || sb_exp.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end_run();
    end

    initial begin
        int a0, w0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!busy, "R1 busy low", int'(busy), 0);
        chk(!bit_out, "R1 bit_out zero", int'(bit_out), 0);
        chk(dram_addr == 9'd0, "R1 column zero", int'(dram_addr), 0);

        // R2/R7: record up to the first column wrap
        for (int i = 0; i < 512; i++) sample(2'b00, pat(3, i));
        drain();
        chk(n_cbr == 1, "R7 one row step at column wrap", n_cbr, 1);
        chk(n_acc == 512, "R2 accesses", n_acc, 512);
        for (int i = 512; i < L; i++) sample(2'b00, pat(3, i));
        drain();
        chk(n_cbr == 256, "R8 row steps to return home", n_cbr, 256);
        chk(refcnt == 0, "R8 memory row counter at zero", refcnt, 0);
        chk(n_we == L, "R2 one write per record strobe", n_we, L);

        // R3: play, both encodings
        w0 = n_we; c0 = n_cbr;
        for (int i = 0; i < 550; i++) sample(2'b01, 1'b1);
        for (int i = 550; i < L; i++) sample(2'b11, 1'b1);
        drain();
        chk(n_we == w0, "R3 no write in play", n_we - w0, 0);
        chk(n_cbr - c0 == 256, "R8 row steps in play pass", n_cbr - c0, 256);

        // R4: delay across more than one ring length
        w0 = n_we;
        for (int i = 0; i < 700; i++) sample(2'b10, pat(11, i));
        drain();
        chk(n_we - w0 == 700, "R4 one write per delay strobe", n_we - w0, 700);
        chk(refcnt == 0, "R8 row counter after delay pass", refcnt, 0);

        // R9: strobe while busy is ignored
        a0 = n_acc; w0 = n_we;
        @(negedge clk);
        while (busy) @(negedge clk);
        smp_stb = 1'b1; mode = 2'b01; bit_in = 1'b0;
        expect_item(2'b01, 1'b0);
        @(negedge clk);
        chk(busy, "R9 busy after accept", int'(busy), 1);
        mode = 2'b00; bit_in = 1'b1;
        repeat (3) @(negedge clk);
        smp_stb = 1'b0;
        drain();
        chk(n_acc - a0 == 1, "R9 single access", n_acc - a0, 1);
        chk(n_we == w0, "R9 ignored strobe wrote nothing", n_we - w0, 0);
        for (int i = 0; i < 20; i++) sample(2'b01, 1'b0);
        sample(2'b00, 1'b0);
        drain();

        // R5: strobe ordering over the whole run
        chk(we_bad == 0, "R5 WE only with RAS and CAS low", we_bad, 0);
        chk(rcd_bad == 0, "R5 RAS-to-CAS hold", rcd_bad, 0);
        end_run();
    end

endmodule